// File: doc/BRIEF.md
# Serial Hex-Record Program Loader for Multiple Cores

This block fills the local instruction memories of a group of processor cores from a single asynchronous serial line. The host sends one text stream, which is a series of hexadecimal record images placed back to back, one image for each core. A built-in serial receiver turns the line into characters. A record parser rebuilds the fields of each record, checks them, and packs the data bytes into 32-bit instruction words. A word writer then puts those words into the program memory of the core that is currently selected, through one write-enable line per core.

Loading starts at reset with core 0 selected. An end-of-file record finishes the image of the current core and moves the selection on to the next core. Every core is held in reset for the whole of loading. After the end-of-file record of the last core is accepted, all cores leave reset on the same clock edge. From then on the loader ignores the serial line until the next reset.

A record is written to memory only when all of it has been received and found valid. A record that is bad in any way changes no memory and does not move the core selection. It sets an error flag that stays set until reset.

Top module: `hexrec_core_loader`

## Requirements
- R1: The receiver takes 8 data bits, least-significant bit first, with no parity and one stop bit. Each bit lasts CLKS_PER_BIT clocks and is sampled at its middle. A character whose stop bit is sampled low is discarded, and it has no effect on the record being parsed.
- R2: A record starts with the colon character (0x3A). It is followed by hex-digit pairs giving, in order: a byte count, a 16-bit address (high byte first), a record type, the data bytes, and a checksum byte. Digits 0-9, A-F and a-f are accepted. Characters outside a record, such as line ends, are ignored.
- R3: A record is accepted only when the 8-bit sum of all its bytes, checksum included, is zero. Otherwise it writes nothing, does not move the core selection, and sets the error flag.
- R4: In a data record (type 0x00), the data bytes are packed four to a word, with the first byte in bits 31:24. Word k of the record goes to word address (record address / 4) + k of the selected core. The words are written on consecutive cycles with ascending addresses.
- R5: A data record is rejected with the error flag set in any of these cases: its address is not a multiple of 4, its byte count is not a multiple of 4, its byte count exceeds MAX_REC_BYTES, or its last word falls beyond MEM_DEPTH-1. A record whose last word lands exactly on MEM_DEPTH-1 is accepted. A data record with a count of zero writes nothing.
- R6: A character inside a record that is not a hex digit abandons the record and sets the error flag. If that character is a colon, it also starts a new record.
- R7: An accepted end-of-file record (type 0x01) moves the selection to the next core. Accepted records of any other type have no effect.
- R8: At most one write enable is active in any cycle, and only the one that belongs to the selected core.
- R9: The core-hold output is high from reset until the end-of-file record of core NUM_CORES-1 is accepted. It then goes low for all cores at once and stays low. After that, serial input causes no writes.
- R10: The error flag is low after reset and stays high once it is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| rx_i | input | 1 | Serial receive line, high when idle |
| prog_we_o | output | NUM_CORES | One program-memory write enable per core |
| prog_addr_o | output | $clog2(MEM_DEPTH) | Word address of the write, shared by all cores |
| prog_wdata_o | output | 32 | Instruction word being written, shared by all cores |
| core_hold_o | output | 1 | High while every core must be held in reset |
| load_err_o | output | 1 | Sticky flag for any rejected record or stray character |

## Verification
Some properties are checked by assertions on every cycle: the write enables are one-hot or idle, the addresses within a write burst step up by one, a new burst never starts while one is running, the hold output never rises again once it has dropped, no write occurs after release, the error flag never clears, and the receiver's valid pulse lasts only one cycle. Other behaviour only the bench scenarios can show. This covers checksum rejection, packing byte order, routing of each image to the correct core, the alignment and range limits, and the discarding of a character with a bad stop bit. It also covers the claim that an abandoned record leaves memory untouched. In every one of these cases the bench compares the contents of each core's memory, rebuilt from the write ports, with a model.

// File: rtl/hexload_pkg.sv
package hexload_pkg;

   localparam int WORD_BYTES = 4;
   localparam int WORD_W     = 8 * WORD_BYTES;

   localparam logic [7:0] CH_COLON   = 8'h3A;
   localparam logic [7:0] REC_T_DATA = 8'h00;
   localparam logic [7:0] REC_T_EOF  = 8'h01;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_STOP,
      RX_WAITHI
   } rx_state_e;

   typedef enum logic [2:0] {
      PS_IDLE,
      PS_COUNT,
      PS_ADDRH,
      PS_ADDRL,
      PS_TYPE,
      PS_DATA,
      PS_CSUM,
      PS_DONE
   } parse_state_e;

   typedef struct packed {
      logic       ok;
      logic [3:0] val;
   } nibble_t;

   // ASCII hex digit to value; ok is low for any other character
   function automatic nibble_t decode_hex(input logic [7:0] c);
      nibble_t r;
      r.ok  = 1'b1;
      r.val = 4'h0;
      if (c >= 8'h30 && c <= 8'h39) begin
         r.val = c[3:0];
      end else if ((c >= 8'h41 && c <= 8'h46) || (c >= 8'h61 && c <= 8'h66)) begin
         r.val = c[3:0] + 4'd9;
      end else begin
         r.ok = 1'b0;
      end
      return r;
   endfunction

endpackage

// File: rtl/hexload_uart_rx.sv
module hexload_uart_rx #(
   parameter int CLKS_PER_BIT = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_i,
   output logic       byte_valid_o,
   output logic [7:0] byte_o
);
   import hexload_pkg::*;

   localparam int CNT_W = $clog2(CLKS_PER_BIT);
   localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(CLKS_PER_BIT - 1);
   localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(CLKS_PER_BIT / 2 - 1);

   logic             sync1_q, sync2_q;
   rx_state_e        st_q;
   logic [CNT_W-1:0] cnt_q;
   logic [2:0]       bit_q;
   logic [7:0]       shift_q;
   logic             valid_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync1_q <= 1'b1;
         sync2_q <= 1'b1;
         st_q    <= RX_IDLE;
         cnt_q   <= '0;
         bit_q   <= '0;
         shift_q <= '0;
         valid_q <= 1'b0;
      end else begin
         sync1_q <= rx_i;
         sync2_q <= sync1_q;
         valid_q <= 1'b0;
         case (st_q)
            RX_IDLE: begin
               if (!sync2_q) begin
                  st_q  <= RX_START;
                  cnt_q <= '0;
               end
            end
            RX_START: begin
               if (cnt_q == HALF_LAST) begin
                  cnt_q <= '0;
                  bit_q <= '0;
                  st_q  <= sync2_q ? RX_IDLE : RX_DATA;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            RX_DATA: begin
               if (cnt_q == FULL_LAST) begin
                  cnt_q   <= '0;
                  shift_q <= {sync2_q, shift_q[7:1]};
                  bit_q   <= bit_q + 1'b1;
                  if (bit_q == 3'd7) st_q <= RX_STOP;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            RX_STOP: begin
               if (cnt_q == FULL_LAST) begin
                  cnt_q <= '0;
                  if (sync2_q) begin
                     valid_q <= 1'b1;
                     st_q    <= RX_IDLE;
                  end else begin
                     st_q <= RX_WAITHI;
                  end
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            RX_WAITHI: begin
               if (sync2_q) st_q <= RX_IDLE;
            end
            default: st_q <= RX_IDLE;
         endcase
      end
   end

   assign byte_valid_o = valid_q;
   assign byte_o       = shift_q;

   // R1: each received character is a single-cycle strobe
   a_r1_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid_o |=> !byte_valid_o)
      else $error("a_r1_single_strobe");

endmodule

// File: rtl/hexload_record_parser.sv
module hexload_record_parser #(
   parameter int NUM_CORES     = 2,
   parameter int MEM_DEPTH     = 512,
   parameter int MAX_REC_BYTES = 16,
   localparam int MAX_WORDS    = MAX_REC_BYTES / 4,
   localparam int WIDX_W       = $clog2(MAX_WORDS),
   localparam int WCNT_W       = WIDX_W + 1,
   localparam int ADDR_W       = $clog2(MEM_DEPTH),
   localparam int CORE_W       = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_valid_i,
   input  logic [7:0]        char_i,
   input  logic [WIDX_W-1:0] rd_idx_i,
   output logic [31:0]       word_o,
   output logic              wr_start_o,
   output logic [ADDR_W-1:0] wr_base_o,
   output logic [WCNT_W-1:0] wr_words_o,
   output logic [CORE_W-1:0] core_idx_o,
   output logic              core_hold_o,
   output logic              load_err_o
);
   import hexload_pkg::*;

   localparam int BIDX_W = $clog2(MAX_REC_BYTES);

   parse_state_e      st_q;
   logic              want_hi_q;
   logic [3:0]        hi_q;
   logic [7:0]        sum_q, cnt_q, type_q, idx_q;
   logic [15:0]       addr_q;
   logic [CORE_W-1:0] core_q;
   logic              err_q, start_q;
   logic [7:0]        buf_q [MAX_REC_BYTES];

   nibble_t     nib;
   logic [7:0]  full_byte, total;
   logic [16:0] end_word;
   logic        shape_ok, byte_done;

   always_comb begin
      nib       = decode_hex(char_i);
      full_byte = {hi_q, nib.val};
      total     = sum_q + full_byte;
      end_word  = {3'b000, addr_q[15:2]} + {11'b0, cnt_q[7:2]};
      shape_ok  = (addr_q[1:0] == 2'b00) && (cnt_q[1:0] == 2'b00) &&
                  (int'(cnt_q) <= MAX_REC_BYTES) && (end_word <= 17'(MEM_DEPTH));
      byte_done = byte_valid_i && nib.ok && !want_hi_q &&
                  (st_q != PS_IDLE) && (st_q != PS_DONE);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= PS_IDLE;
         want_hi_q <= 1'b1;
         hi_q      <= '0;
         sum_q     <= '0;
         cnt_q     <= '0;
         type_q    <= '0;
         idx_q     <= '0;
         addr_q    <= '0;
         core_q    <= '0;
         err_q     <= 1'b0;
         start_q   <= 1'b0;
      end else begin
         start_q <= 1'b0;
         if (byte_valid_i && st_q != PS_DONE) begin
            if (char_i == CH_COLON) begin
               if (st_q != PS_IDLE) err_q <= 1'b1;
               st_q      <= PS_COUNT;
               want_hi_q <= 1'b1;
               sum_q     <= '0;
               idx_q     <= '0;
            end else if (st_q == PS_IDLE) begin
               st_q <= PS_IDLE;
            end else if (!nib.ok) begin
               err_q <= 1'b1;
               st_q  <= PS_IDLE;
            end else if (want_hi_q) begin
               hi_q      <= nib.val;
               want_hi_q <= 1'b0;
            end else begin
               want_hi_q <= 1'b1;
               sum_q     <= total;
               case (st_q)
                  PS_COUNT: begin cnt_q <= full_byte; st_q <= PS_ADDRH; end
                  PS_ADDRH: begin addr_q[15:8] <= full_byte; st_q <= PS_ADDRL; end
                  PS_ADDRL: begin addr_q[7:0] <= full_byte; st_q <= PS_TYPE; end
                  PS_TYPE: begin
                     type_q <= full_byte;
                     st_q   <= (cnt_q == 8'd0) ? PS_CSUM : PS_DATA;
                  end
                  PS_DATA: begin
                     idx_q <= idx_q + 8'd1;
                     if (idx_q == cnt_q - 8'd1) st_q <= PS_CSUM;
                  end
                  PS_CSUM: begin
                     st_q <= PS_IDLE;
                     if (total != 8'd0) begin
                        err_q <= 1'b1;
                     end else if (type_q == REC_T_DATA) begin
                        if (cnt_q != 8'd0) begin
                           if (shape_ok) start_q <= 1'b1;
                           else          err_q   <= 1'b1;
                        end
                     end else if (type_q == REC_T_EOF) begin
                        if (core_q == CORE_W'(NUM_CORES - 1)) st_q <= PS_DONE;
                        else core_q <= core_q + 1'b1;
                     end
                  end
                  default: st_q <= PS_IDLE;
               endcase
            end
         end
      end
   end

   // record data buffer: words are committed only after the checksum
   always_ff @(posedge clk) begin
      if (byte_done && st_q == PS_DATA && int'(idx_q) < MAX_REC_BYTES)
         buf_q[idx_q[BIDX_W-1:0]] <= full_byte;
   end

   logic [31:0] words_w [MAX_WORDS];
   for (genvar w = 0; w < MAX_WORDS; w++) begin : g_pack
      assign words_w[w] = {buf_q[4*w], buf_q[4*w+1], buf_q[4*w+2], buf_q[4*w+3]};
   end

   assign word_o      = words_w[rd_idx_i];
   assign wr_start_o  = start_q;
   assign wr_base_o   = addr_q[ADDR_W+1:2];
   assign wr_words_o  = WCNT_W'(cnt_q[7:2]);
   assign core_idx_o  = core_q;
   assign core_hold_o = (st_q != PS_DONE);
   assign load_err_o  = err_q;

   // R9: release is permanent until reset
   a_r9_release_final: assert property (@(posedge clk) disable iff (!rst_n)
      !core_hold_o |=> !core_hold_o)
      else $error("a_r9_release_final");

   // R9: no record is committed once the cores run
   a_r9_no_commit_released: assert property (@(posedge clk) disable iff (!rst_n)
      !core_hold_o |-> !wr_start_o)
      else $error("a_r9_no_commit_released");

   // R10: error flag never clears
   a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      load_err_o |=> load_err_o)
      else $error("a_r10_err_sticky");

   // R7: selection only ever moves forward by one
   a_r7_select_step: assert property (@(posedge clk) disable iff (!rst_n)
      (core_idx_o != $past(core_idx_o)) |-> (core_idx_o == $past(core_idx_o) + 1'b1))
      else $error("a_r7_select_step");

endmodule

// File: rtl/hexload_word_writer.sv
module hexload_word_writer #(
   parameter int NUM_CORES  = 2,
   parameter int MEM_DEPTH  = 512,
   parameter int MAX_WORDS  = 4,
   localparam int WIDX_W    = $clog2(MAX_WORDS),
   localparam int WCNT_W    = WIDX_W + 1,
   localparam int ADDR_W    = $clog2(MEM_DEPTH),
   localparam int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [ADDR_W-1:0]    base_i,
   input  logic [WCNT_W-1:0]    words_i,
   input  logic [CORE_W-1:0]    core_i,
   input  logic [31:0]          word_i,
   output logic [WIDX_W-1:0]    rd_idx_o,
   output logic [NUM_CORES-1:0] prog_we_o,
   output logic [ADDR_W-1:0]    prog_addr_o,
   output logic [31:0]          prog_wdata_o
);
   logic              busy_q;
   logic [WIDX_W-1:0] idx_q, last_q;
   logic [ADDR_W-1:0] base_q;
   logic [CORE_W-1:0] core_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
         last_q <= '0;
         base_q <= '0;
         core_q <= '0;
      end else if (start_i) begin
         busy_q <= 1'b1;
         idx_q  <= '0;
         last_q <= WIDX_W'(words_i - WCNT_W'(1));
         base_q <= base_i;
         core_q <= core_i;
      end else if (busy_q) begin
         if (idx_q == last_q) busy_q <= 1'b0;
         else                 idx_q  <= idx_q + 1'b1;
      end
   end

   assign rd_idx_o     = idx_q;
   assign prog_addr_o  = base_q + ADDR_W'(idx_q);
   assign prog_wdata_o = word_i;

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_we
      assign prog_we_o[c] = busy_q && (core_q == CORE_W'(c));
   end

   // R8: never more than one core written
   a_r8_onehot_we: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(prog_we_o))
      else $error("a_r8_onehot_we");

   // R4: words of one burst land on ascending consecutive addresses
   a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      ((|prog_we_o) && $past(|prog_we_o)) |-> (prog_addr_o == $past(prog_addr_o) + ADDR_W'(1)))
      else $error("a_r4_addr_step");

   // R4: a burst is never restarted before it ends
   a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !busy_q)
      else $error("a_r4_no_restart");

endmodule

// File: rtl/hexrec_core_loader.sv
module hexrec_core_loader #(
   parameter int NUM_CORES     = 2,
   parameter int MEM_DEPTH     = 512,
   parameter int CLKS_PER_BIT  = 8,
   parameter int MAX_REC_BYTES = 16,
   localparam int ADDR_W       = $clog2(MEM_DEPTH),
   localparam int MAX_WORDS    = MAX_REC_BYTES / 4,
   localparam int WIDX_W       = $clog2(MAX_WORDS),
   localparam int WCNT_W       = WIDX_W + 1,
   localparam int CORE_W       = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rx_i,
   output logic [NUM_CORES-1:0] prog_we_o,
   output logic [ADDR_W-1:0]    prog_addr_o,
   output logic [31:0]          prog_wdata_o,
   output logic                 core_hold_o,
   output logic                 load_err_o
);
   if (NUM_CORES < 1) begin : g_bad_cores
      $error("NUM_CORES must be at least 1");
   end
   if (MAX_REC_BYTES % 4 != 0 || MAX_REC_BYTES < 8 || MAX_REC_BYTES > 252 ||
       (MAX_WORDS & (MAX_WORDS - 1)) != 0) begin : g_bad_rec
      $error("MAX_REC_BYTES must be a multiple of 4 in 8..252 giving a power-of-two word count");
   end
   if ((MEM_DEPTH & (MEM_DEPTH - 1)) != 0 || MEM_DEPTH > 16384 || MEM_DEPTH < MAX_WORDS) begin : g_bad_depth
      $error("MEM_DEPTH must be a power of two between MAX_WORDS and 16384");
   end
   if (CLKS_PER_BIT < 4 || CLKS_PER_BIT * 10 <= MAX_WORDS + 4) begin : g_bad_baud
      $error("CLKS_PER_BIT too small");
   end

   logic              rx_valid;
   logic [7:0]        rx_char;
   logic              wr_start;
   logic [ADDR_W-1:0] wr_base;
   logic [WCNT_W-1:0] wr_words;
   logic [CORE_W-1:0] core_idx;
   logic [WIDX_W-1:0] rd_idx;
   logic [31:0]       rd_word;

   hexload_uart_rx #(
      .CLKS_PER_BIT(CLKS_PER_BIT)
   ) u_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .rx_i        (rx_i),
      .byte_valid_o(rx_valid),
      .byte_o      (rx_char)
   );

   hexload_record_parser #(
      .NUM_CORES    (NUM_CORES),
      .MEM_DEPTH    (MEM_DEPTH),
      .MAX_REC_BYTES(MAX_REC_BYTES)
   ) u_parse (
      .clk         (clk),
      .rst_n       (rst_n),
      .byte_valid_i(rx_valid),
      .char_i      (rx_char),
      .rd_idx_i    (rd_idx),
      .word_o      (rd_word),
      .wr_start_o  (wr_start),
      .wr_base_o   (wr_base),
      .wr_words_o  (wr_words),
      .core_idx_o  (core_idx),
      .core_hold_o (core_hold_o),
      .load_err_o  (load_err_o)
   );

   hexload_word_writer #(
      .NUM_CORES(NUM_CORES),
      .MEM_DEPTH(MEM_DEPTH),
      .MAX_WORDS(MAX_WORDS)
   ) u_wr (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (wr_start),
      .base_i      (wr_base),
      .words_i     (wr_words),
      .core_i      (core_idx),
      .word_i      (rd_word),
      .rd_idx_o    (rd_idx),
      .prog_we_o   (prog_we_o),
      .prog_addr_o (prog_addr_o),
      .prog_wdata_o(prog_wdata_o)
   );

   // R9: memories are quiet while the cores run
   a_r9_quiet_after_release: assert property (@(posedge clk) disable iff (!rst_n)
      !core_hold_o |-> (prog_we_o == '0))
      else $error("a_r9_quiet_after_release");

endmodule

// File: tb/hexrec_core_loader_tb.sv
`timescale 1ns/1ps
module hexrec_core_loader_tb;
   localparam int NC    = 2;
   localparam int DEPTH = 512;
   localparam int CPB   = 8;
   localparam int MAXB  = 16;
   localparam int AW    = $clog2(DEPTH);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx = 1'b1;
   logic [NC-1:0] we;
   logic [AW-1:0] waddr;
   logic [31:0]   wdata;
   logic          hold, err;

   always #2.5 clk = ~clk;

   hexrec_core_loader #(
      .NUM_CORES(NC), .MEM_DEPTH(DEPTH), .CLKS_PER_BIT(CPB), .MAX_REC_BYTES(MAXB)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .rx_i(rx), .prog_we_o(we), .prog_addr_o(waddr),
      .prog_wdata_o(wdata), .core_hold_o(hold), .load_err_o(err)
   );

   int checks = 0, errors = 0, wr_count = 0, multi_we = 0;
   bit done = 0;
   logic [31:0] exp_mem [NC][DEPTH];
   bit          exp_v   [NC][DEPTH];
   logic [31:0] got_mem [NC][DEPTH];
   bit          got_v   [NC][DEPTH];
   logic [7:0]  rec [32];

   always @(negedge clk) begin
      if (rst_n) begin
         if ($countones(we) > 1) multi_we++;
         for (int c = 0; c < NC; c++) begin
            if (we[c]) begin
               got_mem[c][waddr] = wdata;
               got_v[c][waddr]   = 1'b1;
               wr_count++;
            end
         end
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, act, expv);
      end
   endtask

   task automatic clear_models();
      for (int c = 0; c < NC; c++)
         for (int a = 0; a < DEPTH; a++) begin
            exp_v[c][a] = 0; got_v[c][a] = 0; exp_mem[c][a] = '0; got_mem[c][a] = '0;
         end
      wr_count = 0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      rx    = 1'b1;
      repeat (5) @(negedge clk);
      clear_models();
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic send_char(input logic [7:0] c, input bit good_stop);
      @(negedge clk);
      rx = 1'b0;
      repeat (CPB) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rx = c[i];
         repeat (CPB) @(negedge clk);
      end
      rx = good_stop;
      repeat (CPB) @(negedge clk);
      rx = 1'b1;
      repeat (CPB) @(negedge clk);
   endtask

   function automatic logic [7:0] hexc(input logic [3:0] n, input bit lower);
      if (n < 4'd10) return 8'h30 + {4'h0, n};
      return (lower ? 8'h61 : 8'h41) + {4'h0, n} - 8'd10;
   endfunction

   task automatic send_hbyte(input logic [7:0] b, input bit lower);
      send_char(hexc(b[7:4], lower), 1'b1);
      send_char(hexc(b[3:0], lower), 1'b1);
   endtask

   // full record from rec[]; bad_pos injects a character with a low stop bit
   task automatic send_record(input int cnt, input logic [15:0] addr, input logic [7:0] typ,
                              input bit bad_csum, input bit lower, input int bad_pos);
      logic [7:0] s;
      s = 8'(cnt) + addr[15:8] + addr[7:0] + typ;
      for (int i = 0; i < cnt; i++) s = s + rec[i];
      s = 8'd0 - s;
      if (bad_csum) s = s + 8'd1;
      send_char(8'h3A, 1'b1);
      send_hbyte(8'(cnt), lower);
      send_hbyte(addr[15:8], lower);
      send_hbyte(addr[7:0], lower);
      send_hbyte(typ, lower);
      for (int i = 0; i < cnt; i++) begin
         if (i == bad_pos) send_char(8'h5A, 1'b0);
         send_hbyte(rec[i], lower);
      end
      send_hbyte(s, lower);
      send_char(8'h0D, 1'b1);
      send_char(8'h0A, 1'b1);
   endtask

   task automatic fill_random(input int cnt);
      for (int i = 0; i < cnt; i++) rec[i] = 8'($urandom);
   endtask

   task automatic model_data(input int core, input int cnt, input logic [15:0] addr);
      for (int k = 0; k < cnt / 4; k++) begin
         exp_mem[core][addr / 4 + k] = {rec[4*k], rec[4*k+1], rec[4*k+2], rec[4*k+3]};
         exp_v[core][addr / 4 + k]   = 1'b1;
      end
   endtask

   task automatic random_data_record(input int core, input int bad_pos);
      int cnt, word;
      logic [15:0] addr;
      cnt  = 4 * $urandom_range(1, MAXB / 4);
      word = $urandom_range(0, DEPTH - cnt / 4);
      addr = 16'(word * 4);
      fill_random(cnt);
      send_record(cnt, addr, 8'h00, 1'b0, 1'($urandom), bad_pos);
      model_data(core, cnt, addr);
   endtask

   task automatic compare_core(input int c, input string req);
      int mism = 0, first = -1;
      for (int a = 0; a < DEPTH; a++) begin
         if (exp_v[c][a] != got_v[c][a] || (exp_v[c][a] && exp_mem[c][a] != got_mem[c][a])) begin
            mism++;
            if (first < 0) first = a;
         end
      end
      if (first < 0) check(1'b1, req, "memory image", 0, 0);
      else check(1'b0, req, $sformatf("memory image core %0d word %0d", c, first),
                 got_mem[c][first], exp_mem[c][first]);
   endtask

   task automatic expect_reject(input string req, input string what);
      repeat (10) @(negedge clk);
      check(err == 1'b1, req, {what, " error flag"}, 32'(err), 1);
      check(wr_count == 0, req, {what, " no write"}, wr_count, 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R9 watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int wc;
      void'($urandom(32'h5EED_0042));
      do_reset();
      // reset state
      check(hold == 1'b1, "R9", "hold after reset", 32'(hold), 1);
      check(err == 1'b0, "R10", "error after reset", 32'(err), 0);
      check(we == '0, "R8", "enables after reset", 32'(we), 0);

      // R3: wrong checksum is rejected
      fill_random(8);
      send_record(8, 16'h0040, 8'h00, 1'b1, 1'b0, -1);
      expect_reject("R3", "bad checksum");

      // R5: shape violations
      do_reset();
      fill_random(8);
      send_record(8, 16'h0042, 8'h00, 1'b0, 1'b0, -1);
      expect_reject("R5", "misaligned address");
      do_reset();
      fill_random(6);
      send_record(6, 16'h0000, 8'h00, 1'b0, 1'b0, -1);
      expect_reject("R5", "count not multiple of four");
      do_reset();
      fill_random(20);
      send_record(20, 16'h0000, 8'h00, 1'b0, 1'b0, -1);
      expect_reject("R5", "oversize record");
      do_reset();
      fill_random(16);
      send_record(16, 16'(510 * 4), 8'h00, 1'b0, 1'b0, -1);
      expect_reject("R5", "beyond last word");

      // R6: stray character abandons the record, next colon restarts
      do_reset();
      send_char(8'h3A, 1'b1);
      send_hbyte(8'h04, 1'b0);
      send_char(8'h47, 1'b1);
      fill_random(8);
      send_record(8, 16'h0010, 8'h00, 1'b0, 1'b0, -1);
      model_data(0, 8, 16'h0010);
      repeat (10) @(negedge clk);
      check(err == 1'b1, "R6", "non-hex char error", 32'(err), 1);
      check(wr_count == 2, "R6", "record after stray char written", wr_count, 2);
      compare_core(0, "R6");
      do_reset();
      send_char(8'h3A, 1'b1);
      send_hbyte(8'h08, 1'b0);
      fill_random(4);
      send_record(4, 16'h0020, 8'h00, 1'b0, 1'b1, -1);
      model_data(0, 4, 16'h0020);
      repeat (10) @(negedge clk);
      check(err == 1'b1, "R6", "colon mid-record error", 32'(err), 1);
      compare_core(0, "R6");

      // main load of both cores
      do_reset();
      for (int r = 0; r < 6; r++) random_data_record(0, (r == 2) ? 1 : -1);
      send_char(8'h78, 1'b1);
      send_char(8'h79, 1'b1);
      wc = wr_count;
      fill_random(2);
      send_record(2, 16'h0000, 8'h04, 1'b0, 1'b0, -1);
      send_record(0, 16'h0100, 8'h00, 1'b0, 1'b0, -1);
      repeat (10) @(negedge clk);
      check(wr_count == wc, "R7", "other type and empty record write nothing", wr_count, wc);
      check(err == 1'b0, "R2", "chars outside records ignored", 32'(err), 0);
      send_record(0, 16'h0000, 8'h01, 1'b0, 1'b0, -1);
      repeat (10) @(negedge clk);
      check(hold == 1'b1, "R9", "hold after first image", 32'(hold), 1);
      for (int r = 0; r < 6; r++) random_data_record(1, -1);
      fill_random(16);
      send_record(16, 16'(508 * 4), 8'h00, 1'b0, 1'b1, -1);
      model_data(1, 16, 16'(508 * 4));
      check(hold == 1'b1, "R9", "hold before last end record", 32'(hold), 1);
      send_record(0, 16'h0000, 8'h01, 1'b0, 1'b0, -1);
      repeat (10) @(negedge clk);
      check(hold == 1'b0, "R9", "release after last image", 32'(hold), 0);
      check(err == 1'b0, "R3", "valid stream raises no error", 32'(err), 0);
      compare_core(0, "R4");
      compare_core(1, "R4");
      check(multi_we == 0, "R8", "cycles with several enables", multi_we, 0);

      // R1 framing discard and R9 input ignored after release
      wc = wr_count;
      fill_random(8);
      send_record(8, 16'h0000, 8'h00, 1'b0, 1'b0, -1);
      repeat (10) @(negedge clk);
      check(wr_count == wc, "R9", "no write after release", wr_count, wc);
      check(hold == 1'b0, "R9", "hold stays low", 32'(hold), 0);
      compare_core(0, "R1");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule